// File: doc/BRIEF.md
# Windowed Watchdog Timer with Service Key

This block is a watchdog counter that advances on a slow tick enable and asks for a system reset when software stops servicing it correctly. An 8-bit configuration byte is captured while reset is held. It is captured again in the cycle after every reset request the block raises. The byte decides three things: whether the counter runs, how many ticks make up the overflow period, and how much of that period is a closed window in which servicing is forbidden.

Software services the watchdog by writing a key byte. Each write carries its data byte and a flag that marks it as a single-bit manipulation. The block raises a one-cycle reset request in four cases: the period runs out, the key is wrong, the write is a bit manipulation, or a service after the first one lands in the closed window. The first service after a reset is exempt from the window check. A correct service clears the counter to zero. The block only requests a reset; the system reset controller and clock generation are outside it.

Top module: `win_watchdog`

## Requirements
- R1: While `rst_n` is low (synchronous, active low), `rst_req` is 0 and `cfg_byte` is captured. After release, changes on `cfg_byte` have no effect until the next reset or reset request.
- R2: With captured bit 4 at 0, the counter stays stopped. Without writes, `rst_req` never rises.
- R3: With captured bit 4 at 1, the period is 2^(7+S) ticks, where S is captured bits 3:1. When the tick that completes the period arrives with no valid service in that cycle, `rst_req` rises at the next clock edge.
- R4: A write of 0xAC with the bit flag low that is not rejected clears the counter to zero. This holds even in the cycle that carries the final tick of the period, and that overflow is then cancelled.
- R5: The first accepted service after reset, or after a reset request, is allowed at any count.
- R6: Captured bits 6:5 set the closed window. Code 01 is closed while count < P/2, code 10 while count < P/4, and codes 11 and 00 are never closed. A later service in the closed window raises `rst_req` at the next edge.
- R7: A write whose data is not 0xAC raises `rst_req` at the next edge.
- R8: A write with `wr_bitop` high raises `rst_req` at the next edge, even when its data is 0xAC.
- R9: `rst_req` is high for exactly one cycle. Writes in that cycle are ignored. The counter and the first-service state then return to their reset values, and `cfg_byte` is captured again during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Low-speed count enable |
| cfg_byte | input | 8 | Configuration byte: bit 4 run, bits 3:1 period, bits 6:5 window |
| wr_en | input | 1 | Write strobe to the service register |
| wr_data | input | 8 | Write data byte |
| wr_bitop | input | 1 | Write is a single-bit manipulation |
| rst_req | output | 1 | One-cycle internal reset request |

## Verification
The bench aims a correct key at the cycle that carries the final tick. A design that lets overflow win there resets a healthy system. It serves at exactly P/4-1, P/4, P/2-1 and P/2 counts. An off-by-one window comparison either rejects a legal service or accepts an illegal one. It also tries a service in the closed window as the very first write, which a design without the exemption rejects. It changes `cfg_byte` after release and again during a request pulse, so a design that captures at the wrong time runs with the wrong period or stays stopped. It sends a bad key inside the pulse cycle: a design that does not ignore it produces a second pulse.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int BASE_LOG = 7;
    localparam int SEL_W    = 3;
    localparam int NUM_SEL  = 1 << SEL_W;
    localparam int CNT_W    = BASE_LOG + NUM_SEL - 1;

    localparam logic [7:0] SERVICE_KEY = 8'hAC;

    localparam int RUN_POS = 4;
    localparam int SEL_LSB = 1;
    localparam int WIN_LSB = 5;

    typedef enum logic [1:0] {
        WIN_OPEN_ALT = 2'b00,
        WIN_HALF     = 2'b01,
        WIN_QUARTER  = 2'b10,
        WIN_OPEN     = 2'b11
    } win_code_e;

    typedef struct packed {
        logic [7:0] cfg;
        logic       served;
        logic       req;
    } wdt_state_t;

endpackage

// File: rtl/wdt_cfg_decode.sv
module wdt_cfg_decode #(
    parameter int BASE_LOG = wdt_pkg::BASE_LOG,
    parameter int SEL_W    = wdt_pkg::SEL_W,
    parameter int CNT_W    = wdt_pkg::CNT_W
) (
    input  logic [7:0]       cfg,
    output logic             run,
    output logic [CNT_W-1:0] last,
    output logic [CNT_W-1:0] closed
);
    import wdt_pkg::*;

    localparam int NSEL = 1 << SEL_W;

    logic [CNT_W-1:0] last_tab [NSEL];
    logic [SEL_W-1:0] sel;
    win_code_e        win;
    logic [CNT_W-1:0] half_len;
    logic [CNT_W-1:0] quarter_len;
    logic             spare_unused;

    for (genvar g = 0; g < NSEL; g++) begin : g_period
        assign last_tab[g] = CNT_W'((1 << (BASE_LOG + g)) - 1);
    end

    assign sel          = cfg[SEL_LSB +: SEL_W];
    assign win          = win_code_e'(cfg[WIN_LSB +: 2]);
    assign run          = cfg[RUN_POS];
    assign spare_unused = ^{cfg[7], cfg[0]};

    always_comb begin
        last        = last_tab[sel];
        half_len    = (last >> 1) + CNT_W'(1);
        quarter_len = (last >> 2) + CNT_W'(1);
        unique case (win)
            WIN_HALF:    closed = half_len;
            WIN_QUARTER: closed = quarter_len;
            default:     closed = '0;
        endcase
    end

endmodule

// File: rtl/wdt_key_check.sv
module wdt_key_check #(
    parameter int CNT_W = wdt_pkg::CNT_W
) (
    input  logic             busy,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             wr_bitop,
    input  logic             served,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] closed,
    output logic             clr,
    output logic             wfault
);
    import wdt_pkg::*;

    logic key_ok;
    logic in_closed;

    always_comb begin
        key_ok    = (wr_data == SERVICE_KEY) && !wr_bitop;
        in_closed = served && (cnt < closed);
        clr       = 1'b0;
        wfault    = 1'b0;
        if (wr_en && !busy) begin
            if (key_ok && !in_closed) clr    = 1'b1;
            else                      wfault = 1'b1;
        end
    end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CNT_W = wdt_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             clr,
    input  logic             hold,
    input  logic [CNT_W-1:0] last,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf
);
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        ovf   = run && tick && (cnt_q == last);
        cnt_d = cnt_q;
        if (!rst_n || hold || clr) cnt_d = '0;
        else if (run && tick)      cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/win_watchdog.sv
module win_watchdog #(
    parameter int BASE_LOG = wdt_pkg::BASE_LOG,
    parameter int SEL_W    = wdt_pkg::SEL_W,
    parameter int CNT_W    = BASE_LOG + (1 << SEL_W) - 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic [7:0] cfg_byte,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       wr_bitop,
    output logic       rst_req
);
    import wdt_pkg::*;

    wdt_state_t       st_d, st_q;
    logic             run_w;
    logic [CNT_W-1:0] last_w;
    logic [CNT_W-1:0] closed_w;
    logic [CNT_W-1:0] cnt_q;
    logic             ovf_w;
    logic             clr_w;
    logic             wfault_w;
    logic             fault_w;
    logic             hold_w;
    logic             served_q;

    assign served_q = st_q.served;

    wdt_cfg_decode #(
        .BASE_LOG(BASE_LOG), .SEL_W(SEL_W), .CNT_W(CNT_W)
    ) u_decode (
        .cfg(st_q.cfg), .run(run_w), .last(last_w), .closed(closed_w)
    );

    wdt_key_check #(.CNT_W(CNT_W)) u_key (
        .busy(st_q.req), .wr_en(wr_en), .wr_data(wr_data), .wr_bitop(wr_bitop),
        .served(st_q.served), .cnt(cnt_q), .closed(closed_w),
        .clr(clr_w), .wfault(wfault_w)
    );

    assign fault_w = rst_n && !st_q.req && (wfault_w || (ovf_w && !clr_w));
    assign hold_w  = st_q.req || fault_w;

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run_w), .tick(tick_en),
        .clr(clr_w), .hold(hold_w), .last(last_w),
        .cnt_q(cnt_q), .ovf(ovf_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        if (!rst_n || st_q.req) begin
            st_d.cfg    = cfg_byte;
            st_d.served = 1'b0;
        end else if (fault_w) begin
            st_d.served = 1'b0;
            st_d.req    = 1'b1;
        end else if (clr_w) begin
            st_d.served = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rst_req = st_q.req;

endmodule

// File: rtl/win_watchdog_chk.sv
module win_watchdog_chk #(
    parameter int CNT_W = wdt_pkg::CNT_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             wr_en,
    input logic [7:0]       wr_data,
    input logic             wr_bitop,
    input logic             rst_req,
    input logic             run,
    input logic             served,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] last,
    input logic [CNT_W-1:0] closed
);
    p_pulse_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    p_pulse_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> (cnt == '0) && !served);

    p_stopped_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !wr_en && !rst_req |=> !rst_req);

    p_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run && tick_en && (cnt == last) && !wr_en && !rst_req |=> rst_req);

    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= last);

    p_first_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_bitop && (wr_data == 8'hAC) && !served && !rst_req
        |=> !rst_req && (cnt == '0) && served);

    p_closed_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && served && (cnt < closed) && !rst_req |=> rst_req);

    p_bad_key_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_data != 8'hAC) && !rst_req |=> rst_req);

    p_bitop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_bitop && !rst_req |=> rst_req);

endmodule

bind win_watchdog win_watchdog_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_data(wr_data), .wr_bitop(wr_bitop), .rst_req(rst_req),
    .run(run_w), .served(served_q), .cnt(cnt_q), .last(last_w),
    .closed(closed_w)
);

// File: tb/win_watchdog_bench.sv
module win_watchdog_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic [7:0] cfg_byte = 8'h00;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wr_bitop = 1'b0;
    logic       rst_req;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [7:0] m_cfg = 8'h00;
    int         m_cnt = 0;
    bit         m_served = 0;
    bit         m_req = 0;
    string      m_why = "R1";
    string      cur_tag = "R1";

    always #10 clk = ~clk;

    win_watchdog u_win_watchdog (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cfg_byte(cfg_byte),
        .wr_en(wr_en), .wr_data(wr_data), .wr_bitop(wr_bitop), .rst_req(rst_req)
    );

    function automatic int period_of(input logic [7:0] c);
        return 1 << (7 + int'(c[3:1]));
    endfunction

    function automatic int closed_of(input logic [7:0] c);
        case (c[6:5])
            2'b01:   return period_of(c) / 2;
            2'b10:   return period_of(c) / 4;
            default: return 0;
        endcase
    endfunction

    task automatic model_next(input bit ti, input bit we, input logic [7:0] wd, input bit wb);
        bit fault = 0;
        bit clr = 0;
        if (!rst_n || m_req) begin
            m_cfg = cfg_byte; m_cnt = 0; m_served = 0;
            m_why = !rst_n ? "R1 reset" : "R9 pulse end";
            m_req = 0;
            return;
        end
        m_why = cur_tag;
        if (we) begin
            if (wb)               begin fault = 1; m_why = "R8 bit write"; end
            else if (wd != 8'hAC) begin fault = 1; m_why = "R7 bad key"; end
            else if (m_served && m_cnt < closed_of(m_cfg))
                                  begin fault = 1; m_why = "R6 closed window"; end
            else clr = 1;
        end
        if (!fault && !clr && m_cfg[4] && ti) begin
            if (m_cnt == period_of(m_cfg) - 1) begin fault = 1; m_why = "R3 overflow"; end
            else m_cnt++;
        end
        if (fault) begin m_cnt = 0; m_served = 0; m_req = 1; end
        else if (clr) begin m_cnt = 0; m_served = 1; m_req = 0; end
        else m_req = 0;
    endtask

    task automatic step(input bit ti, input bit we, input logic [7:0] wd, input bit wb);
        @(negedge clk);
        tick_en = ti; wr_en = we; wr_data = wd; wr_bitop = wb;
        model_next(ti, we, wd, wb);
        @(posedge clk);
        #1;
        checks++;
        if (rst_req !== m_req) begin
            errors++;
            $display("FAIL %s: rst_req actual %0b expected %0b", m_why, rst_req, m_req);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 8'h00, 1'b0);
    endtask

    task automatic serve(input logic [7:0] d, input bit b);
        step(1'b1, 1'b1, d, b);
    endtask

    task automatic do_reset(input logic [7:0] c);
        cfg_byte = c;
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 8'h00, 1'b0);
        rst_n = 1'b1;
    endtask

    function automatic logic [7:0] mk_cfg(input bit run, input int sel, input int win);
        return {1'b0, 2'(win), run, 3'(sel), 1'b0};
    endfunction

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                errors++;
                $display("FAIL watchdog: cycles actual %0d expected below 190000", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin : stim
        void'($urandom(32'd1234));

        cur_tag = "R1 reset state";
        do_reset(mk_cfg(1, 0, 3));
        cur_tag = "R1 capture held";
        cfg_byte = mk_cfg(0, 7, 1);
        idle(127);
        cur_tag = "R3 overflow";
        idle(1);
        idle(2);

        cur_tag = "R3 slow ticks";
        do_reset(mk_cfg(1, 1, 3));
        for (int i = 0; i < 260; i++) step(1'(i % 2), 1'b0, 8'h00, 1'b0);

        cur_tag = "R4 clear at last tick";
        do_reset(mk_cfg(1, 0, 3));
        idle(127);
        serve(8'hAC, 0);
        idle(127);
        serve(8'hAC, 0);
        idle(130);

        cur_tag = "R5 first exempt";
        do_reset(mk_cfg(1, 0, 1));
        idle(5);
        serve(8'hAC, 0);
        cur_tag = "R6 half closed";
        idle(63);
        serve(8'hAC, 0);
        idle(2);
        serve(8'hAC, 0);
        idle(64);
        serve(8'hAC, 0);

        cur_tag = "R6 quarter";
        do_reset(mk_cfg(1, 0, 2));
        serve(8'hAC, 0);
        idle(31);
        serve(8'hAC, 0);
        idle(2);
        serve(8'hAC, 0);
        idle(32);
        serve(8'hAC, 0);

        cur_tag = "R6 code zero open";
        do_reset(mk_cfg(1, 0, 0));
        serve(8'hAC, 0);
        serve(8'hAC, 0);
        idle(3);

        cur_tag = "R7 wrong key";
        do_reset(mk_cfg(1, 0, 3));
        idle(4);
        serve(8'h53, 0);
        idle(2);
        cur_tag = "R8 bit write";
        serve(8'hAC, 1);
        idle(2);

        cur_tag = "R2 stopped";
        do_reset(mk_cfg(0, 0, 3));
        idle(600);

        cur_tag = "R9 pulse and recapture";
        do_reset(mk_cfg(1, 0, 3));
        serve(8'hAC, 0);
        serve(8'h11, 0);
        cfg_byte = mk_cfg(0, 0, 1);
        serve(8'h22, 0);
        cfg_byte = mk_cfg(1, 0, 3);
        idle(300);

        cur_tag = "R4 random quiet";
        for (int blk = 0; blk < 16; blk++) begin
            do_reset(mk_cfg(($urandom % 8) != 0, int'($urandom % 3), int'($urandom % 4)));
            for (int i = 0; i < 1500; i++) begin
                bit ti = ($urandom % 4) != 0;
                bit we = ($urandom % 60) == 0;
                int r = int'($urandom % 100);
                logic [7:0] d = (r < 90) ? 8'hAC : 8'($urandom);
                bit b = (r == 99);
                if (($urandom % 50) == 0) cfg_byte = 8'($urandom);
                step(ti, we, d, b);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule